// File: doc/BRIEF.md
# DSP Program Sequencer with Branch Conditions

This block computes the next program counter of a small DSP. The counter is 14 bits wide. Each cycle that `adv` is high, the sequencer reads the 24-bit instruction word that is currently executing. It uses the two most significant bits of that word to pick one of four instruction classes.

- Classes 0 and 3 step the counter by one.
- Class 1 is a return. It pops the counter from an internal return stack.
- Class 2 is a branch. A 9-bit branch code in bits 21:13 selects the action:
  - a jump to the value held in an external shift-out register,
  - a conditional jump on an accumulator flag,
  - a conditional jump on the low nibble of the data pointer,
  - a conditional jump on the host request flag,
  - an unconditional long jump,
  - a call.

The branch target is assembled from three parts. Bits 10:0 come from the 11-bit address field in instruction bits 12:2. Bits 12:11 come from the 2-bit bank field in instruction bits 1:0. Bit 13 is either carried from the incremented counter or forced by the instruction.

The instruction memory, the ALU and the registers that produce the flags sit outside the block. The flags of accumulators A and B, the data-pointer nibble, the request flag and the shift-out value arrive as plain inputs. The sequencer only decides where execution goes next.

Top module: `prog_seq`

## Requirements
- R1: Synchronous active-high reset sets the counter to 0. It also clears the stack pointer and every stack entry to 0, so a return issued right after reset yields counter 0.
- R2: While `adv` is low the counter and the stack stay unchanged, whatever the instruction word holds.
- R3: With `adv` high, instruction classes 0 and 3 (bits 23:22 = 00 or 11) load the counter with counter+1, modulo 2^14.
- R4: The jump target is {bit 13, bank, address}. Codes 0x100 and 0x101 jump unconditionally with bit 13 forced to 0 and to 1 respectively. For the conditional codes, bit 13 is taken from counter+1.
- R5: Branch code 0x000 loads the counter from bits 13:0 of `so_val` without any condition. Bits 15:14 of `so_val` are ignored.
- R6: The flag ports carry the flags at these bit positions: 0 = carry, 1 = zero, 2 = overflow0, 3 = overflow1, 4 = sign0, 5 = sign1.
  - Codes 0x080 to 0x0AE (even codes only) test those flags in that bit order, two codes apart.
  - Each flag uses four consecutive even codes, in this order: jump if A clear, if A set, if B clear, if B set.
- R7: Codes 0x0B0, 0x0B1, 0x0B2 and 0x0B3 jump when `dp_low` is zero, non-zero, 0xF and not 0xF respectively.
- R8: Code 0x0BC jumps when `rqm` is 0, and code 0x0BE jumps when `rqm` is 1.
- R9: A conditional branch whose condition is false, and any branch code not listed in R4 to R10, load counter+1.
- R10: Codes 0x140 and 0x141 push counter+1 onto the return stack. They then jump to the target with bit 13 forced to 0 and to 1 respectively.
- R11: A class-1 instruction decrements the stack pointer, then loads the counter from the entry it now points at.
  - The stack holds DEPTH entries (a power of two, default 4).
  - The pointer wraps silently on both overflow and underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Execute the current instruction this cycle |
| instr | input | 24 | Instruction word being executed |
| flags_a | input | 6 | Accumulator A flags {s1,s0,ov1,ov0,z,c} |
| flags_b | input | 6 | Accumulator B flags {s1,s0,ov1,ov0,z,c} |
| dp_low | input | 4 | Low nibble of the data pointer |
| rqm | input | 1 | Host request flag |
| so_val | input | 16 | Shift-out register value |
| pc | output | 14 | Program counter |

## Verification
The bench sweeps all 512 branch codes under several flag, nibble and request patterns. Before each vector it sets counter bit 13 to a known value, so that any mis-decoded flag index, A/B swap or inverted polarity shows up as a wrong taken/not-taken counter. It lands a conditional jump on 0x1FFF, where the incremented counter carries into bit 13. A design that took bit 13 from the unincremented counter would land 0x2000 too low there. Six calls are followed by six returns on a four-deep stack. A design that saturated instead of wrapping, or that popped without pre-decrementing, would return to the wrong addresses.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int PC_W    = 14;
    localparam int INSTR_W = 24;
    localparam int CODE_W  = 9;
    localparam int ADDR_W  = 11;
    localparam int BANK_W  = 2;
    localparam int NFLAGS  = 6;

    typedef enum logic [1:0] {
        CL_ALU = 2'd0,
        CL_RET = 2'd1,
        CL_BRA = 2'd2,
        CL_IMM = 2'd3
    } iclass_t;

    typedef struct packed {
        logic s1;
        logic s0;
        logic ov1;
        logic ov0;
        logic z;
        logic c;
    } acc_flags_t;

    typedef struct packed {
        logic [1:0]        cls;
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
    } bra_word_t;

    typedef enum logic [1:0] {
        NX_SEQ = 2'd0,
        NX_TGT = 2'd1,
        NX_SO  = 2'd2,
        NX_POP = 2'd3
    } nxt_sel_t;

    typedef enum logic [1:0] {
        HI_KEEP = 2'd0,
        HI_ZERO = 2'd1,
        HI_ONE  = 2'd2
    } hi_mode_t;

    typedef struct packed {
        nxt_sel_t sel;
        hi_mode_t hi;
        logic     push;
        logic     pop;
    } seq_ctl_t;

    localparam logic [CODE_W-1:0] C_SO    = 9'h000;
    localparam logic [CODE_W-1:0] C_LJ0   = 9'h100;
    localparam logic [CODE_W-1:0] C_LJ1   = 9'h101;
    localparam logic [CODE_W-1:0] C_CALL0 = 9'h140;
    localparam logic [CODE_W-1:0] C_CALL1 = 9'h141;
    localparam logic [CODE_W-1:0] C_RQ0   = 9'h0BC;
    localparam logic [CODE_W-1:0] C_RQ1   = 9'h0BE;

    // Select one flag by its index in the fixed port order.
    function automatic logic pick_flag(acc_flags_t f, logic [2:0] idx);
        case (idx)
            3'd0:    pick_flag = f.c;
            3'd1:    pick_flag = f.z;
            3'd2:    pick_flag = f.ov0;
            3'd3:    pick_flag = f.ov1;
            3'd4:    pick_flag = f.s0;
            3'd5:    pick_flag = f.s1;
            default: pick_flag = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import seq_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  acc_flags_t        fa,
    input  acc_flags_t        fb,
    input  logic [3:0]        dp_low,
    input  logic              rqm,
    output logic              known,
    output logic              hit
);
    logic [4:0] k;
    logic       fbit;

    always_comb begin
        known = 1'b0;
        hit   = 1'b0;
        k     = code[5:1];
        fbit  = pick_flag(k[1] ? fb : fa, k[4:2]);
        if (code[8:6] == 3'b010) begin
            if (!code[0] && code[5:0] <= 6'h2E) begin
                // even codes: flag group in k[4:2], accumulator in k[1], polarity in k[0]
                known = 1'b1;
                hit   = (fbit == k[0]);
            end else if (code[5:2] == 4'b1100) begin
                known = 1'b1;
                case (code[1:0])
                    2'd0: hit = (dp_low == 4'h0);
                    2'd1: hit = (dp_low != 4'h0);
                    2'd2: hit = (dp_low == 4'hF);
                    2'd3: hit = (dp_low != 4'hF);
                endcase
            end else if (code == C_RQ0) begin
                known = 1'b1;
                hit   = !rqm;
            end else if (code == C_RQ1) begin
                known = 1'b1;
                hit   = rqm;
            end
        end
    end

endmodule

// File: rtl/branch_decode.sv
module branch_decode
    import seq_pkg::*;
(
    input  bra_word_t w,
    input  logic      known,
    input  logic      hit,
    output seq_ctl_t  ctl
);
    always_comb begin
        ctl.sel  = NX_SEQ;
        ctl.hi   = HI_KEEP;
        ctl.push = 1'b0;
        ctl.pop  = 1'b0;
        case (iclass_t'(w.cls))
            CL_RET: begin
                ctl.sel = NX_POP;
                ctl.pop = 1'b1;
            end
            CL_BRA: begin
                case (w.code)
                    C_SO:  ctl.sel = NX_SO;
                    C_LJ0: begin ctl.sel = NX_TGT; ctl.hi = HI_ZERO; end
                    C_LJ1: begin ctl.sel = NX_TGT; ctl.hi = HI_ONE;  end
                    C_CALL0: begin
                        ctl.sel = NX_TGT; ctl.hi = HI_ZERO; ctl.push = 1'b1;
                    end
                    C_CALL1: begin
                        ctl.sel = NX_TGT; ctl.hi = HI_ONE; ctl.push = 1'b1;
                    end
                    default: if (known && hit) ctl.sel = NX_TGT;
                endcase
            end
            default: ctl.sel = NX_SEQ;
        endcase
    end

    // R11 / R10: a word never both pushes and pops
    always_comb begin
        a_push_pop_excl_r11: assert (!(ctl.push && ctl.pop));
    end

endmodule

// File: rtl/return_stack.sv
module return_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] pop_val
);
    localparam int SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]   mem [DEPTH];
    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_dec;

    assign sp_dec  = sp - 1'b1;
    assign pop_val = mem[sp_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp + 1'b1;
        end else if (pop) begin
            sp <= sp_dec;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (push && sp == SPW'(i)) begin
                mem[i] <= push_val;
            end
        end
    end

    p_push_sp_r10: assert property (@(posedge clk) disable iff (rst)
        push |=> sp == $past(sp) + 1'b1);

    p_pop_sp_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> sp == $past(sp) - 1'b1);

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import seq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [INSTR_W-1:0] instr,
    input  logic [NFLAGS-1:0]  flags_a,
    input  logic [NFLAGS-1:0]  flags_b,
    input  logic [3:0]         dp_low,
    input  logic               rqm,
    input  logic [15:0]        so_val,
    output logic [PC_W-1:0]    pc
);
    bra_word_t       w;
    seq_ctl_t        ctl;
    logic            known;
    logic            hit;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] pop_val;
    logic            hi_bit;

    assign w      = bra_word_t'(instr);
    assign pc_inc = pc + 1'b1;

    cond_eval u_cond (
        .code   (w.code),
        .fa     (acc_flags_t'(flags_a)),
        .fb     (acc_flags_t'(flags_b)),
        .dp_low (dp_low),
        .rqm    (rqm),
        .known  (known),
        .hit    (hit)
    );

    branch_decode u_dec (
        .w     (w),
        .known (known),
        .hit   (hit),
        .ctl   (ctl)
    );

    return_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (adv && ctl.push),
        .pop      (adv && ctl.pop),
        .push_val (pc_inc),
        .pop_val  (pop_val)
    );

    always_comb begin
        case (ctl.hi)
            HI_ZERO: hi_bit = 1'b0;
            HI_ONE:  hi_bit = 1'b1;
            default: hi_bit = pc_inc[PC_W-1];
        endcase
        target = {hi_bit, w.bank, w.addr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (adv) begin
            case (ctl.sel)
                NX_TGT:  pc <= target;
                NX_SO:   pc <= so_val[PC_W-1:0];
                NX_POP:  pc <= pop_val;
                default: pc <= pc_inc;
            endcase
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pc));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && (instr[23:22] == 2'b00 || instr[23:22] == 2'b11))
        |=> pc == $past(pc) + 1'b1);

    p_so_jump_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && instr[23:13] == 11'b10_000000000)
        |=> pc == $past(so_val[PC_W-1:0]));

    p_call_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (adv && instr[23:22] == 2'b10 && instr[21:14] == 8'hA0)
        |=> pc[PC_W-1] == $past(instr[13]));

endmodule

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        adv;
    logic [23:0] instr;
    logic [5:0]  flags_a, flags_b;
    logic [3:0]  dp_low;
    logic        rqm;
    logic [15:0] so_val;
    logic [13:0] pc;

    int n_chk  = 0;
    int n_fail = 0;
    int m_pc   = 0;
    int m_sp   = 0;
    int m_stk [D];

    always #10 clk = ~clk;

    prog_seq #(.DEPTH(D)) dut (
        .clk(clk), .rst(rst), .adv(adv), .instr(instr),
        .flags_a(flags_a), .flags_b(flags_b), .dp_low(dp_low),
        .rqm(rqm), .so_val(so_val), .pc(pc)
    );

    task automatic check(input string tag, input int exp);
        n_chk++;
        if (int'(pc) != exp) begin
            n_fail++;
            $display("FAIL %s: pc actual %h expected %h", tag, pc, exp[13:0]);
        end
    endtask

    function automatic string tag_of(input int code);
        if (code == 0) return "R5";
        if (code == 256 || code == 257) return "R4";
        if (code == 320 || code == 321) return "R10";
        if (code >= 128 && code <= 174 && code % 2 == 0) return "R6";
        if (code >= 176 && code <= 179) return "R7";
        if (code == 188 || code == 190) return "R8";
        return "R9";
    endfunction

    // Reference next-counter computed from the requirements.
    task automatic step(input logic [23:0] ins, input logic [5:0] fa, input logic [5:0] fb,
                        input logic [3:0] dp, input logic rq, input logic [15:0] so,
                        input string tag);
        int cls, code, tl, inc, expv, k, fs;
        bit hit;
        logic [5:0] f;
        cls  = int'(ins[23:22]);
        code = int'(ins[21:13]);
        tl   = int'({ins[1:0], ins[12:2]});
        inc  = (m_pc + 1) % 16384;
        expv = inc;
        if (cls == 1) begin
            m_sp = (m_sp + D - 1) % D;
            expv = m_stk[m_sp];
        end else if (cls == 2) begin
            if (code == 0) expv = int'(so[13:0]);
            else if (code == 256) expv = tl;
            else if (code == 257) expv = 8192 + tl;
            else if (code == 320 || code == 321) begin
                m_stk[m_sp] = inc;
                m_sp = (m_sp + 1) % D;
                expv = (code == 321 ? 8192 : 0) + tl;
            end else begin
                hit = 0;
                if (code >= 128 && code <= 174 && code % 2 == 0) begin
                    k  = (code - 128) / 2;
                    fs = k / 4;
                    f  = ((k % 4) >= 2) ? fb : fa;
                    hit = (f[fs] == bit'(k % 2));
                end else if (code == 176) hit = (dp == 0);
                else if (code == 177) hit = (dp != 0);
                else if (code == 178) hit = (dp == 15);
                else if (code == 179) hit = (dp != 15);
                else if (code == 188) hit = !rq;
                else if (code == 190) hit = rq;
                if (hit) expv = (inc / 8192) * 8192 + tl;
            end
        end
        @(negedge clk);
        instr = ins; flags_a = fa; flags_b = fb; dp_low = dp; rqm = rq; so_val = so; adv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        adv  = 1'b0;
        m_pc = expv;
        check(tag, expv);
    endtask

    function automatic logic [23:0] bra(input int code, input int addr, input int bank);
        return {2'b10, 9'(code), 11'(addr), 2'(bank)};
    endfunction

    initial begin : watchdog
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < D; i++) m_stk[i] = 0;
        rst = 1'b1; adv = 1'b0; instr = '0; flags_a = '0; flags_b = '0;
        dp_low = '0; rqm = 1'b0; so_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 0);

        // R3 sequential classes
        step(24'h000000, 6'h0, 6'h0, 4'h0, 0, 16'h0, "R3");
        step(24'hC12345, 6'h3F, 6'h3F, 4'hF, 1, 16'hFFFF, "R3");
        // R1 stack cleared: return pops a zero entry
        step(24'h400000, 6'h0, 6'h0, 4'h0, 0, 16'h0, "R1");

        // R2 hold with adv low
        @(negedge clk);
        instr = bra(257, 'h555, 2); adv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2", m_pc);

        // R5 upper so bits ignored
        step(bra(0, 0, 0), 6'h0, 6'h0, 4'h0, 0, 16'hC123, "R5");

        // R4 carry of counter+1 into bit 13 feeds conditional target
        step(bra(256, 'h7FF, 3), 6'h0, 6'h0, 4'h0, 0, 16'h0, "R4");
        step(bra(177, 'h012, 1), 6'h0, 6'h0, 4'h5, 0, 16'h0, "R4");

        // Sweep of every branch code under several input patterns
        for (int code = 0; code < 512; code++) begin
            for (int p = 0; p < 6; p++) begin
                step(bra(((code + p) % 2 == 0) ? 257 : 256, (code * 3 + p) % 2048, p % 4),
                     6'h0, 6'h0, 4'h0, 0, 16'h0, "R4");
                step(bra(code, (code * 7 + p * 13) % 2048, (p + code) % 4),
                     6'((p * 11 + code) % 64), 6'((p * 37 + code * 5) % 64),
                     4'((code + p * 3) % 16), 1'((code / 2 + p) % 2),
                     16'((code * 97 + p * 4099) % 65536), tag_of(code));
            end
        end

        // R10 / R11 deep call chain with wrap, then unwinding
        for (int i = 0; i < 6; i++)
            step(bra(320 + (i % 2), 'h100 + i * 5, i % 4), 6'h0, 6'h0, 4'h0, 0, 16'h0, "R10");
        for (int i = 0; i < 6; i++)
            step(24'h4ABCDE, 6'h0, 6'h0, 4'h0, 0, 16'h0, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule